// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Minute Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour count), day of month, weekday, month and a two-digit year in the range 2000 to 2099. A one-cycle 1 Hz enable pulse advances the count. Month lengths and leap years are tracked. Software reaches the block through a flat register port. Writes are synchronous with `wr_en`. Reads are combinational on `addr`.

A four-field alarm covers minute, hour, day and weekday. Each field carries its own match-disable bit. The alarm is evaluated only when the minute rolls over. A hit sets a sticky flag in the second control register, and software clears that flag by writing it to zero. The active-low `irq_n` output asserts while both the flag and the alarm interrupt enable are set. The first control register provides a stop bit that freezes the count. A fixed command byte written to that register performs a software reset. An oscillator-stopped marker in the seconds register shows that the time is not trustworthy.

Top module: `bcd_rtc_core`

## Requirements
- R1: After `rst_n` is released, the block holds this state:
  - Time is 00:00:00 on day 01, month 01, year 00, weekday 6.
  - The oscillator-stopped marker is set.
  - Both control registers read 0x00.
  - All four alarm registers read 0x80.
  - `irq_n` is high.
- R2: The register addresses are:
  - 0x0 and 0x1: control registers.
  - 0x2 to 0x8: seconds, minutes, hours, day, weekday, month, year.
  - 0x9 to 0xC: alarm minute, alarm hour, alarm day, alarm weekday.

  Time fields read back only their valid bits (7, 7, 6, 6, 3, 5 and 8 bits) with the upper bits as zero. Addresses 0xD to 0xF read 0x00, and writes to them are ignored.
- R3: Each `tick_1hz` pulse advances the seconds in BCD. The carries run as follows:
  - Seconds 59 wrap to 00 and increment the minutes.
  - Minutes 59 wrap to 00 and increment the hours.
  - Hours 23 wrap to 00, increment the day, and advance the weekday, which runs 0 to 6 and then back to 0.
- R4: The day wraps to 01 after the last day of the month:
  - 28 days in February, or 29 when the year is divisible by 4.
  - 30 days in April, June, September and November.
  - 31 days in every other month.

  Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R5: While control 1 bit 5 is set, ticks are ignored and the time holds. Writing 0x00 to control 1 resumes counting.
- R6: Writing exactly 0x58 (bits 6, 4 and 3) to control 1 is a software reset:
  - Both control registers clear.
  - Every alarm register becomes 0x80.
  - The oscillator-stopped marker sets.
  - The time fields keep their values.

  Any other byte written to control 1 is stored and read back unchanged, including bit 2 (12-hour select) and bit 1 (correction interrupt enable).
- R7: Bit 7 of the seconds register is the oscillator-stopped marker. Power-on reset and software reset set it. Any write to the seconds register clears it.
- R8: When the minute rolls over, each alarm register with bit 7 clear is compared with its time field in the new time. The compare uses the valid bits only. If at least one field is enabled and every enabled field is equal, the alarm flag (control 2 bit 3) sets. If the minute or any enabled field differs, the flag is not set.
- R9: The alarm flag is sticky. Writing 0 to control 2 bit 3 clears it, and writing 1 leaves it unchanged. All other control 2 bits are stored as written.
- R10: `irq_n` is low exactly while the alarm flag and the alarm interrupt enable (control 2 bit 1) are both set.
- R11: If an alarm hit and a control 2 write that clears the flag fall in the same cycle, the flag ends up set.
- R12: A write to any time register (0x2 to 0x8) in the same cycle as a tick takes the written value. The whole tick in that cycle is discarded, including the seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Alarm interrupt, active low |

## Verification
Two events can land in the same cycle. An alarm hit, produced by a tick that rolls the minute over, can coincide with a software write that clears the alarm flag. The bench drives the tick and a control 2 write of 0x02 on the same clock edge, then reads control 2 back and expects 0x0A with `irq_n` low, because the set has priority. A second collision pairs a tick with a write to the minutes register. The bench expects the written minute and unchanged seconds, since the whole tick in that cycle is dropped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // Register addresses (low four bits of the port address)
   localparam logic [3:0] A_CTL1 = 4'h0;
   localparam logic [3:0] A_CTL2 = 4'h1;
   localparam logic [3:0] A_SEC  = 4'h2;
   localparam logic [3:0] A_MIN  = 4'h3;
   localparam logic [3:0] A_HOUR = 4'h4;
   localparam logic [3:0] A_DAY  = 4'h5;
   localparam logic [3:0] A_WDAY = 4'h6;
   localparam logic [3:0] A_MON  = 4'h7;
   localparam logic [3:0] A_YEAR = 4'h8;
   localparam logic [3:0] A_ALM0 = 4'h9;

   // Control 2 bit positions used by logic
   localparam int C2_AIE = 1;
   localparam int C2_AF  = 3;

   typedef struct packed {
      logic       os;
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [5:0] day;
      logic [2:0] wday;
      logic [4:0] mon;
      logic [7:0] year;
   } rtc_time_t;

   // Increment a two-digit BCD value (no wrap handling beyond the digit)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // Last day of a BCD month, given a BCD year 00..99
   function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
      logic leap;
      logic [5:0] r;
      if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
      case (mon)
         5'h02:                      r = leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
         default:                    r = 6'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
   import rtc_pkg::*;
#(
   parameter logic [2:0] RESET_WDAY = 3'd6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       sw_rst,
   output rtc_time_t  t_q,
   output rtc_time_t  t_next,
   output logic       roll_min
);

   localparam rtc_time_t T_RESET = '{os: 1'b1, sec: 7'h00, min: 7'h00, hour: 6'h00,
                                    day: 6'h01, wday: RESET_WDAY, mon: 5'h01, year: 8'h00};

   logic [7:0] s_i, m_i, h_i, d_i, mo_i, y_i;
   logic       sec_w, min_w, hr_w, day_w, mon_w;
   logic       time_wr;
   rtc_time_t  t_d;

   assign s_i  = bcd_inc({1'b0, t_q.sec});
   assign m_i  = bcd_inc({1'b0, t_q.min});
   assign h_i  = bcd_inc({2'b0, t_q.hour});
   assign d_i  = bcd_inc({2'b0, t_q.day});
   assign mo_i = bcd_inc({3'b0, t_q.mon});
   assign y_i  = bcd_inc(t_q.year);

   assign time_wr = wr_en && (wr_addr >= A_SEC) && (wr_addr <= A_YEAR);

   // Carry chain: next time if a tick is applied
   always_comb begin
      t_next = t_q;
      sec_w  = (t_q.sec  == 7'h59);
      min_w  = (t_q.min  == 7'h59);
      hr_w   = (t_q.hour == 6'h23);
      day_w  = (t_q.day  == month_len(t_q.mon, t_q.year));
      mon_w  = (t_q.mon  == 5'h12);
      t_next.sec = sec_w ? 7'h00 : s_i[6:0];
      if (sec_w) begin
         t_next.min = min_w ? 7'h00 : m_i[6:0];
         if (min_w) begin
            t_next.hour = hr_w ? 6'h00 : h_i[5:0];
            if (hr_w) begin
               t_next.wday = (t_q.wday >= 3'd6) ? 3'd0 : t_q.wday + 3'd1;
               t_next.day  = day_w ? 6'h01 : d_i[5:0];
               if (day_w) begin
                  t_next.mon = mon_w ? 5'h01 : mo_i[4:0];
                  if (mon_w) t_next.year = (t_q.year == 8'h99) ? 8'h00 : y_i;
               end
            end
         end
      end
   end

   assign roll_min = adv && sec_w && !time_wr;

   always_comb begin
      t_d = t_q;
      if (time_wr) begin
         case (wr_addr)
            A_SEC:   begin t_d.sec = wr_data[6:0]; t_d.os = 1'b0; end
            A_MIN:   t_d.min  = wr_data[6:0];
            A_HOUR:  t_d.hour = wr_data[5:0];
            A_DAY:   t_d.day  = wr_data[5:0];
            A_WDAY:  t_d.wday = wr_data[2:0];
            A_MON:   t_d.mon  = wr_data[4:0];
            default: t_d.year = wr_data;
         endcase
      end else if (adv) begin
         t_d = t_next;
      end
      if (sw_rst) t_d.os = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t_q <= T_RESET;
      else        t_q <= t_d;
   end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_pkg::*;
#(
   parameter int FIELDS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [3:0]             wr_addr,
   input  logic [7:0]             wr_data,
   input  logic                   sw_rst,
   input  logic                   roll_min,
   input  rtc_time_t              t_next,
   output logic [FIELDS-1:0][7:0] alm_q,
   output logic                   hit
);

   localparam logic [7:0] ALM_OFF = 8'h80;

   if (FIELDS != 4) begin : g_bad_fields
      $error("rtc_alarm_match: FIELDS must be 4");
   end

   logic [FIELDS-1:0] en, eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < FIELDS; i++) alm_q[i] <= ALM_OFF;
      end else if (sw_rst) begin
         for (int i = 0; i < FIELDS; i++) alm_q[i] <= ALM_OFF;
      end else if (wr_en) begin
         for (int i = 0; i < FIELDS; i++)
            if (wr_addr == A_ALM0 + 4'(i)) alm_q[i] <= wr_data;
      end
   end

   for (genvar g = 0; g < FIELDS; g++) begin : g_field
      logic [7:0] fv, mask;
      if (g == 0) begin : g_min
         assign fv = {1'b0, t_next.min};  assign mask = 8'h7F;
      end else if (g == 1) begin : g_hour
         assign fv = {2'b0, t_next.hour}; assign mask = 8'h3F;
      end else if (g == 2) begin : g_day
         assign fv = {2'b0, t_next.day};  assign mask = 8'h3F;
      end else begin : g_wday
         assign fv = {5'b0, t_next.wday}; assign mask = 8'h07;
      end
      assign en[g] = ~alm_q[g][7];
      assign eq[g] = (((alm_q[g] ^ fv) & mask) == 8'h00);
   end

   assign hit = roll_min && (|en) && (&(eq | ~en));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int         ADDR_W     = 4,
   parameter int         DATA_W     = 8,
   parameter logic [7:0] SWRST_CODE = 8'h58,
   parameter int         STOP_BIT   = 5,
   parameter logic [2:0] RESET_WDAY = 3'd6,
   parameter int         ALM_FIELDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq_n
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("bcd_rtc_core: ADDR_W must be at least 4");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("bcd_rtc_core: DATA_W must be 8");
   end
   if (STOP_BIT < 0 || STOP_BIT > 7) begin : g_bad_stop
      $error("bcd_rtc_core: STOP_BIT out of range");
   end

   logic                       in_map;
   logic [3:0]                 a_lo;
   logic                       wr_sel, sw_rst, adv, hit, roll_min;
   logic [7:0]                 ctl1_q, ctl2_q, ctl2_d;
   logic [ALM_FIELDS-1:0][7:0] alm_q;
   rtc_time_t                  t_cur, t_next;

   if (ADDR_W > 4) begin : g_wide
      assign in_map = (addr[ADDR_W-1:4] == '0);
   end else begin : g_narrow
      assign in_map = 1'b1;
   end

   assign a_lo   = addr[3:0];
   assign wr_sel = wr_en && in_map;
   assign sw_rst = wr_sel && (a_lo == A_CTL1) && (wdata == SWRST_CODE);
   assign adv    = tick_1hz && !ctl1_q[STOP_BIT];

   rtc_time_counter #(.RESET_WDAY(RESET_WDAY)) u_time (
      .clk(clk), .rst_n(rst_n), .adv(adv), .wr_en(wr_sel), .wr_addr(a_lo),
      .wr_data(wdata), .sw_rst(sw_rst), .t_q(t_cur), .t_next(t_next), .roll_min(roll_min)
   );

   rtc_alarm_match #(.FIELDS(ALM_FIELDS)) u_alarm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sel), .wr_addr(a_lo), .wr_data(wdata),
      .sw_rst(sw_rst), .roll_min(roll_min), .t_next(t_next), .alm_q(alm_q), .hit(hit)
   );

   // Control 1: plain storage, except the reset command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctl1_q <= 8'h00;
      else if (sw_rst)                     ctl1_q <= 8'h00;
      else if (wr_sel && a_lo == A_CTL1)   ctl1_q <= wdata;
   end

   // Control 2: alarm flag is clear-only from software, hardware set wins
   always_comb begin
      ctl2_d = ctl2_q;
      if (wr_sel && a_lo == A_CTL2) begin
         ctl2_d        = wdata;
         ctl2_d[C2_AF] = ctl2_q[C2_AF] & wdata[C2_AF];
      end
      if (hit) ctl2_d[C2_AF] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl2_q <= 8'h00;
      else if (sw_rst) ctl2_q <= 8'h00;
      else             ctl2_q <= ctl2_d;
   end

   assign irq_n = ~(ctl2_q[C2_AF] & ctl2_q[C2_AIE]);

   always_comb begin
      rdata = 8'h00;
      if (in_map) begin
         case (a_lo)
            A_CTL1:  rdata = ctl1_q;
            A_CTL2:  rdata = ctl2_q;
            A_SEC:   rdata = {t_cur.os, t_cur.sec};
            A_MIN:   rdata = {1'b0, t_cur.min};
            A_HOUR:  rdata = {2'b0, t_cur.hour};
            A_DAY:   rdata = {2'b0, t_cur.day};
            A_WDAY:  rdata = {5'b0, t_cur.wday};
            A_MON:   rdata = {3'b0, t_cur.mon};
            A_YEAR:  rdata = t_cur.year;
            4'h9:    rdata = alm_q[0];
            4'hA:    rdata = alm_q[1];
            4'hB:    rdata = alm_q[2];
            4'hC:    rdata = alm_q[3];
            default: rdata = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic              irq_n,
   input logic              stop,
   input logic              os,
   input logic [6:0]        sec,
   input logic              af
);

   logic tw;
   assign tw = wr_en && (addr >= 2) && (addr <= 8);

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !stop && !tw && sec == 7'h59) |=> (sec == 7'h00)); // R3

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !tw) |=> $stable(sec)); // R5

   AST_SWRST_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 0 && wdata == 8'h58) |=> (os && !stop && !af)); // R6

   AST_OS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2) |=> !os); // R7

   AST_AF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (af && !(wr_en && (addr == 0 || addr == 1))) |=> af); // R9

   AST_AIE_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 1 && !wdata[1]) |=> irq_n); // R10

endmodule

bind bcd_rtc_core rtc_core_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en), .addr(addr),
   .wdata(wdata), .irq_n(irq_n), .stop(ctl1_q[STOP_BIT]), .os(t_cur.os),
   .sec(t_cur.sec), .af(ctl2_q[3])
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_n;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   bcd_rtc_core dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic tick_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick_1hz = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); addr = a; #1;
      chk(req, rdata, exp);
   endtask

   task automatic set_time(input logic [7:0] yr, mo, dy, wd, hr, mi, se);
      wr(4'h8, yr); wr(4'h7, mo); wr(4'h5, dy); wr(4'h6, wd);
      wr(4'h4, hr); wr(4'h3, mi); wr(4'h2, se);
   endtask

   task automatic t_reset();
      rd(4'h2, 8'h80, "R1 sec with marker"); rd(4'h3, 8'h00, "R1 min");
      rd(4'h4, 8'h00, "R1 hour"); rd(4'h5, 8'h01, "R1 day");
      rd(4'h6, 8'h06, "R1 wday"); rd(4'h7, 8'h01, "R1 month");
      rd(4'h8, 8'h00, "R1 year"); rd(4'h0, 8'h00, "R1 ctl1");
      rd(4'h1, 8'h00, "R1 ctl2");
      for (int i = 9; i <= 12; i++) rd(4'(i), 8'h80, "R1 alarm");
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
      rd(4'hD, 8'h00, "R2 unmapped read");
      wr(4'hE, 8'hFF); rd(4'hE, 8'h00, "R2 unmapped write ignored");
   endtask

   task automatic t_count();
      wr(4'h2, 8'hD8);
      rd(4'h2, 8'h58, "R7 marker cleared by sec write");
      tick(); rd(4'h2, 8'h59, "R3 sec inc");
      tick(); rd(4'h2, 8'h00, "R3 sec wrap");
      rd(4'h3, 8'h01, "R3 min carry");
      wr(4'h4, 8'hFF); rd(4'h4, 8'h3F, "R2 hour width mask");
      set_time(8'h00, 8'h01, 8'h05, 8'h06, 8'h23, 8'h59, 8'h59);
      tick();
      rd(4'h4, 8'h00, "R3 hour wrap"); rd(4'h5, 8'h06, "R3 day inc");
      rd(4'h6, 8'h00, "R3 wday wrap");
   endtask

   task automatic t_calendar();
      set_time(8'h01, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
      rd(4'h5, 8'h01, "R4 feb non-leap day"); rd(4'h7, 8'h03, "R4 feb non-leap month");
      set_time(8'h04, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
      rd(4'h5, 8'h29, "R4 feb leap day"); rd(4'h7, 8'h02, "R4 feb leap month");
      set_time(8'h04, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); tick();
      rd(4'h5, 8'h01, "R4 30-day month"); rd(4'h7, 8'h05, "R4 30-day month next");
      set_time(8'h04, 8'h01, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); tick();
      rd(4'h5, 8'h31, "R4 31-day month");
      set_time(8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59); tick();
      rd(4'h7, 8'h01, "R4 month wrap"); rd(4'h8, 8'h00, "R4 year wrap");
      rd(4'h5, 8'h01, "R4 day wrap dec");
   endtask

   task automatic t_stop();
      wr(4'h2, 8'h10);
      wr(4'h0, 8'h20); rd(4'h0, 8'h20, "R5 stop readback");
      tick(); tick(); tick();
      rd(4'h2, 8'h10, "R5 frozen");
      wr(4'h0, 8'h00); tick();
      rd(4'h2, 8'h11, "R5 resumed");
   endtask

   task automatic t_swreset();
      wr(4'h0, 8'h06); rd(4'h0, 8'h06, "R6 ctl1 stored");
      wr(4'h1, 8'h12); wr(4'h9, 8'h05);
      wr(4'h0, 8'h58);
      rd(4'h0, 8'h00, "R6 ctl1 cleared"); rd(4'h1, 8'h00, "R6 ctl2 cleared");
      rd(4'h9, 8'h80, "R6 alarm off");
      rd(4'h2, 8'h91, "R7 marker set, sec kept");
   endtask

   task automatic t_alarm();
      set_time(8'h10, 8'h06, 8'h15, 8'h03, 8'h10, 8'h29, 8'h59);
      wr(4'h9, 8'h30); wr(4'hA, 8'h10); wr(4'hB, 8'h80); wr(4'hC, 8'h80);
      wr(4'h1, 8'h02);
      tick();
      rd(4'h1, 8'h0A, "R8 alarm hit");
      chk("R10 irq low", {7'b0, irq_n}, 8'h00);
      wr(4'h1, 8'h0A); rd(4'h1, 8'h0A, "R9 write 1 keeps flag");
      wr(4'h1, 8'h08); rd(4'h1, 8'h08, "R9 other bits stored");
      chk("R10 irq high with enable off", {7'b0, irq_n}, 8'h01);
      wr(4'h1, 8'h02); rd(4'h1, 8'h02, "R9 write 0 clears");
      chk("R10 irq released", {7'b0, irq_n}, 8'h01);
      wr(4'hA, 8'h11); wr(4'h9, 8'h31); wr(4'h2, 8'h59);
      tick();
      rd(4'h1, 8'h02, "R8 hour mismatch no hit");
      wr(4'hA, 8'h10); wr(4'h9, 8'h00); wr(4'h2, 8'h59);
      tick();
      rd(4'h1, 8'h02, "R8 minute mismatch no hit");
   endtask

   task automatic t_collide();
      wr(4'h3, 8'h31); wr(4'h9, 8'h32); wr(4'h2, 8'h59);
      tick_wr(4'h1, 8'h02);
      rd(4'h1, 8'h0A, "R11 set beats clear");
      chk("R11 irq low", {7'b0, irq_n}, 8'h00);
      wr(4'h2, 8'h10);
      tick_wr(4'h3, 8'h45);
      rd(4'h3, 8'h45, "R12 written minute");
      rd(4'h2, 8'h10, "R12 tick dropped");
      tick(); rd(4'h2, 8'h11, "R12 next tick counts");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_calendar();
      t_stop();
      t_swreset();
      t_alarm();
      t_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule